// File: doc/BRIEF.md
# Deflection Output Port Selector

In a bufferless mesh router, a packet that loses output arbitration cannot wait. It has to leave on some other free mesh output in the same cycle. This block chooses that output for every losing packet. For each loser it grades the four mesh outputs on a 0..3 scale. The grade depends on the packet's preferred direction and on where the destination row lies relative to the current row. The block then hands the loser the best-graded output that is still free.

Losing inputs are served one after another within a single cycle. Each output that is handed out is taken off the free set before the next loser looks at it, so no two packets leave on the same output. The local (ejection) output is never offered to a loser. Results are registered. Each deflected packet raises its flag for one cycle, and a per-cycle count of deflections feeds the deflection-rate counter.

Top module: `defl_port_sel`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset with no losers, defl_vld_o, defl_port_o and defl_cnt_o are all zero.
- R2: An input counts as a loser only when pkt_vld_i is 1 and arb_won_i is 0. A winner, or an input with pkt_vld_i at 0, never gets defl_vld_o.
- R3: Direction codes are N=0, E=1, S=2, W=3. The preferred port opt_port_i gets grade 3 and the port opposite it gets grade 0. The free port with the highest grade is chosen, even when only the grade-0 port is free.
- R4: If the preferred port is E or W and cur_y_i equals the loser's dst_y_i, N and S both get grade 2.
- R5: If the preferred port is E or W and cur_y_i is greater than dst_y_i, N gets 2 and S gets 1. If cur_y_i is less than dst_y_i, N gets 1 and S gets 2. North is the direction of decreasing Y.
- R6: If the preferred port is N or S, E and W both get grade 1.
- R7: Between free ports of equal grade, the order N, E, S, W decides, with N first.
- R8: Losers are served in ascending input index. A port given to one loser is removed from the free set before the next loser is served, so no port is handed out twice in a cycle.
- R9: Only ports whose idle_i bit is 1 are handed out (bit index equals the direction code). A loser that finds no free port left gets defl_vld_o at 0.
- R10: Outputs appear one clock after the inputs. defl_vld_o is a one-cycle pulse for each deflected packet, defl_port_o holds its direction code (0 when not deflected), and defl_cnt_o equals the number of deflections in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_vld_i | input | N_IN | Packet present on each input |
| arb_won_i | input | N_IN | Input won its preferred port in arbitration |
| opt_port_i | input | N_IN x 2 | Preferred mesh direction per input |
| cur_y_i | input | YW | Y coordinate of this node |
| dst_y_i | input | N_IN x YW | Destination Y coordinate per input |
| idle_i | input | 4 | Free mesh outputs, indexed by direction code |
| defl_vld_o | output | N_IN | One-cycle deflection pulse per input |
| defl_port_o | output | N_IN x 2 | Assigned direction per input |
| defl_cnt_o | output | $clog2(N_IN+1) | Number of deflections in the cycle |

## Verification
Two effects can land in the same cycle: port grading and contention between losers. With several losers present, the best port for one loser may already have been taken by an earlier loser, so the later loser must fall back to its next grade. The bench provokes this with directed cycles in which several inputs want the same direction, and with cycles in which there are more losers than free ports. It also runs a long stretch of random cycles. A behavioural model serves the losers in order from an integer grade table, and every cycle is judged by comparing each input's pulse and port, plus the count, against that model.

// File: rtl/defl_sel_pkg.sv
package defl_sel_pkg;
  localparam int N_MESH = 4;
  typedef enum logic [1:0] {DIR_N = 2'd0, DIR_E = 2'd1, DIR_S = 2'd2, DIR_W = 2'd3} mdir_e;
  typedef logic [1:0] prio_t;

  function automatic logic [1:0] oh_to_dir(input logic [N_MESH-1:0] oh);
    logic [1:0] d;
    d = '0;
    for (int k = 0; k < N_MESH; k++)
      if (oh[k]) d = 2'(k);
    return d;
  endfunction
endpackage

// File: rtl/defl_loser_det.sv
module defl_loser_det #(
  parameter int N_IN = 5
) (
  input  logic [N_IN-1:0] vld_i,
  input  logic [N_IN-1:0] won_i,
  output logic [N_IN-1:0] lost_o
);
  assign lost_o = vld_i & ~won_i;
endmodule

// File: rtl/defl_prio_calc.sv
module defl_prio_calc
  import defl_sel_pkg::*;
#(
  parameter int YW = 2
) (
  input  logic [1:0]           opt_i,
  input  logic [YW-1:0]        cur_y_i,
  input  logic [YW-1:0]        dst_y_i,
  output prio_t [N_MESH-1:0]   prio_o
);
  prio_t n_pri, s_pri;

  always_comb begin
    if (cur_y_i == dst_y_i) begin
      n_pri = 2'd2; s_pri = 2'd2;
    end else if (cur_y_i > dst_y_i) begin
      n_pri = 2'd2; s_pri = 2'd1;
    end else begin
      n_pri = 2'd1; s_pri = 2'd2;
    end
  end

  always_comb begin
    for (int p = 0; p < N_MESH; p++) begin
      if (2'(p) == opt_i)                prio_o[p] = 2'd3;
      else if (2'(p) == (opt_i ^ 2'd2))  prio_o[p] = 2'd0;
      else if (opt_i[0])                 prio_o[p] = (2'(p) == DIR_N) ? n_pri : s_pri;
      else                               prio_o[p] = 2'd1;
    end
  end
endmodule

// File: rtl/defl_port_pick.sv
module defl_port_pick
  import defl_sel_pkg::*;
(
  input  logic                req_i,
  input  logic [N_MESH-1:0]   avail_i,
  input  prio_t [N_MESH-1:0]  prio_i,
  output logic [N_MESH-1:0]   gnt_o
);
  logic [N_MESH-1:0] cand, lvl_mask;
  logic found;

  // highest grade level with any free port, then lowest index
  always_comb begin
    cand = '0;
    found = 1'b0;
    lvl_mask = '0;
    for (int lvl = 3; lvl >= 0; lvl--) begin
      for (int p = 0; p < N_MESH; p++)
        lvl_mask[p] = avail_i[p] && (prio_i[p] == 2'(lvl));
      if (!found && (|lvl_mask)) begin
        found = 1'b1;
        cand = lvl_mask;
      end
    end
    gnt_o = req_i ? (cand & (~cand + 1'b1)) : '0;
  end
endmodule

// File: rtl/defl_port_sel.sv
module defl_port_sel
  import defl_sel_pkg::*;
#(
  parameter int N_IN = 5,
  parameter int YW   = 2,
  localparam int CW  = $clog2(N_IN + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IN-1:0]          pkt_vld_i,
  input  logic [N_IN-1:0]          arb_won_i,
  input  logic [N_IN-1:0][1:0]     opt_port_i,
  input  logic [YW-1:0]            cur_y_i,
  input  logic [N_IN-1:0][YW-1:0]  dst_y_i,
  input  logic [3:0]               idle_i,
  output logic [N_IN-1:0]          defl_vld_o,
  output logic [N_IN-1:0][1:0]     defl_port_o,
  output logic [CW-1:0]            defl_cnt_o
);
  logic [N_IN-1:0]   lost;
  logic [N_MESH-1:0] avail_c [N_IN+1];
  logic [N_MESH-1:0] gnt     [N_IN];
  logic [N_IN-1:0]          vld_d;
  logic [N_IN-1:0][1:0]     port_d;
  logic [CW-1:0]            cnt_d;

  defl_loser_det #(.N_IN(N_IN)) i_loser (
    .vld_i (pkt_vld_i),
    .won_i (arb_won_i),
    .lost_o(lost)
  );

  assign avail_c[0] = idle_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    prio_t [N_MESH-1:0] prio;

    defl_prio_calc #(.YW(YW)) i_prio (
      .opt_i  (opt_port_i[i]),
      .cur_y_i(cur_y_i),
      .dst_y_i(dst_y_i[i]),
      .prio_o (prio)
    );

    defl_port_pick i_pick (
      .req_i  (lost[i]),
      .avail_i(avail_c[i]),
      .prio_i (prio),
      .gnt_o  (gnt[i])
    );

    assign avail_c[i+1] = avail_c[i] & ~gnt[i];

    AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt[i])) else $error("grant not onehot");  // R8
    AST_GNT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[i] & ~avail_c[i]) == '0) else $error("grant on taken port");  // R9
    AST_NO_STARVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lost[i] && (|avail_c[i])) |-> (|gnt[i])) else $error("loser left unserved");  // R9
    AST_ONLY_LOSERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      defl_vld_o[i] |-> $past(pkt_vld_i[i] && !arb_won_i[i])) else $error("winner deflected");  // R2
    AST_OUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      defl_vld_o[i] |-> ((($past(idle_i) >> defl_port_o[i]) & 4'd1) != 4'd0))
      else $error("output port was not idle");  // R9
  end

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < N_IN; i++) begin
      vld_d[i]  = |gnt[i];
      port_d[i] = oh_to_dir(gnt[i]);
      cnt_d     = cnt_d + CW'(vld_d[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      defl_vld_o  <= '0;
      defl_port_o <= '0;
      defl_cnt_o  <= '0;
    end else begin
      defl_vld_o  <= vld_d;
      defl_port_o <= port_d;
      defl_cnt_o  <= cnt_d;
    end
  end

  logic [N_MESH-1:0] port_use;
  always_comb begin
    port_use = '0;
    for (int i = 0; i < N_IN; i++)
      if (defl_vld_o[i]) port_use = port_use | (N_MESH'(1) << defl_port_o[i]);
  end

  AST_NO_DUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'($countones(port_use)) == defl_cnt_o) else $error("port handed out twice");  // R8
  AST_CNT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'($countones(defl_vld_o)) == defl_cnt_o) else $error("count mismatch");  // R10
endmodule

// File: tb/test_defl_port_sel.sv
`timescale 1ns/1ps
module test_defl_port_sel;
  localparam int N_IN = 5;
  localparam int YW   = 2;
  localparam int CW   = $clog2(N_IN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0]         vld, won;
  logic [N_IN-1:0][1:0]    opt;
  logic [YW-1:0]           cy;
  logic [N_IN-1:0][YW-1:0] dy;
  logic [3:0]              idle;
  logic [N_IN-1:0]         d_vld;
  logic [N_IN-1:0][1:0]    d_port;
  logic [CW-1:0]           d_cnt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  defl_port_sel #(.N_IN(N_IN), .YW(YW)) i_defl_port_sel (
    .clk_i(clk), .rst_ni(rst_n), .pkt_vld_i(vld), .arb_won_i(won),
    .opt_port_i(opt), .cur_y_i(cy), .dst_y_i(dy), .idle_i(idle),
    .defl_vld_o(d_vld), .defl_port_o(d_port), .defl_cnt_o(d_cnt)
  );

  // grade table: R3..R6, N=0 E=1 S=2 W=3
  function automatic int grade(int o, int p, int c, int d);
    if (p == o) return 3;
    if (p == (o + 2) % 4) return 0;
    if (o == 0 || o == 2) return 1;
    if (c == d) return 2;
    if (p == 0) return (c > d) ? 2 : 1;
    return (c > d) ? 1 : 2;
  endfunction

  int e_vld[N_IN], e_port[N_IN], e_cnt;

  task automatic model();
    int free[4];
    for (int p = 0; p < 4; p++) free[p] = idle[p];
    e_cnt = 0;
    for (int i = 0; i < N_IN; i++) begin
      int best = -1, bg = -1;
      e_vld[i] = 0; e_port[i] = 0;
      if (vld[i] && !won[i]) begin
        for (int p = 0; p < 4; p++)
          if (free[p] != 0) begin
            int g = grade(opt[i], p, cy, dy[i]);
            if (g > bg) begin bg = g; best = p; end
          end
        if (best >= 0) begin
          free[best] = 0; e_vld[i] = 1; e_port[i] = best; e_cnt++;
        end
      end
    end
  endtask

  task automatic apply(string tag);
    bit ok;
    model();
    @(negedge clk);
    ok = (int'(d_cnt) == e_cnt);
    for (int i = 0; i < N_IN; i++)
      if (int'(d_vld[i]) != e_vld[i] || int'(d_port[i]) != e_port[i]) ok = 0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: vld=%b port=%h cnt=%0d expected vld=%0d%0d%0d%0d%0d ports=%0d%0d%0d%0d%0d cnt=%0d",
        tag, d_vld, d_port, d_cnt, e_vld[4], e_vld[3], e_vld[2], e_vld[1], e_vld[0],
        e_port[4], e_port[3], e_port[2], e_port[1], e_port[0], e_cnt);
    end
  endtask

  task automatic quiet();
    vld = '0; won = '0; opt = '0; cy = '0; dy = '0; idle = '0;
  endtask

  task automatic one(int o, int c, int d, logic [3:0] id, string tag);
    quiet();
    vld = 5'b00001; opt[0] = 2'(o); cy = YW'(c); dy[0] = YW'(d); idle = id;
    apply(tag);
  endtask

  initial begin
    quiet();
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (d_vld !== '0 || d_port !== '0 || d_cnt !== '0) begin
        fails++;
        $display("FAIL R1: vld=%b port=%h cnt=%0d expected all zero", d_vld, d_port, d_cnt);
      end
    end
    rst_n = 1'b1;
    apply("R1 idle after reset");
    one(1, 1, 1, 4'b1101, "R4 R7 opt E same row -> N");
    one(1, 1, 1, 4'b1100, "R4 opt E same row, S,W free -> S");
    one(3, 2, 0, 4'b0111, "R5 cur>dst -> N");
    one(3, 0, 3, 4'b0111, "R5 cur<dst -> S");
    one(0, 0, 0, 4'b1110, "R6 R7 opt N -> E tie");
    one(0, 0, 0, 4'b1100, "R6 opt N, S,W free -> W");
    one(2, 3, 0, 4'b0001, "R3 only opposite free");
    one(0, 3, 0, 4'b1111, "R3 preferred free");
    one(1, 2, 2, 4'b0000, "R9 nothing free");
    // three losers contending for E
    quiet();
    vld = 5'b00111; opt[0] = 2'd1; opt[1] = 2'd1; opt[2] = 2'd1; idle = 4'b1111;
    apply("R8 ordered service");
    quiet();
    vld = 5'b10101; opt[0] = 2'd0; opt[2] = 2'd0; opt[4] = 2'd0; idle = 4'b0011;
    apply("R9 R8 more losers than ports");
    quiet();
    vld = 5'b11111; won = 5'b11111; idle = 4'b1111;
    apply("R2 winners ignored");
    quiet();
    won = 5'b00000; vld = 5'b00000; idle = 4'b1111;
    apply("R2 invalid ignored");
    apply("R10 pulse drops");
    for (int n = 0; n < 500; n++) begin
      vld = N_IN'($urandom); won = N_IN'($urandom); opt = (2*N_IN)'($urandom);
      cy = YW'($urandom); dy = (YW*N_IN)'($urandom); idle = 4'($urandom);
      apply("R3-mix random R10");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule